// File: doc/BRIEF.md
# Cascaded Display RAM Write Pointer

This block sits in one segment driver of a cascade in which several drivers share a serial bus. It receives command and data events that a bus front end has already decoded. From these it decides whether each display data byte belongs to this driver and should be stored in the local display RAM. It also keeps the local RAM address pointer. The outputs are a one-clock write enable, together with the address and the byte to be written.

Every driver on the bus sees every data byte. Each driver's pointer therefore advances on every byte, whether or not that driver is the selected one. Software that moves from one driver to the next must send a load-pointer command before writing to the new driver. The hardware subaddress pins are sampled only between accesses. A change on those pins in the middle of an access cannot change the result of a device-select decision in that access.

Top module: `cascade_ram_ptr`

## Requirements
- R1: After reset the pointer is 0, the driver is deselected, and ramWe is low.
- R2: A device-select strobe selects this driver when devSelSub equals the latched hardware subaddress, and deselects it otherwise.
- R3: A data strobe while the driver is selected raises ramWe for exactly the following clock. ramAddr carries the pointer value from before that byte, and ramData carries the byte.
- R4: A data strobe while the driver is deselected still advances the pointer, but ramWe stays low.
- R5: A load-pointer strobe sets the pointer to loadAddr, so that following bytes are written from that address upward. A loadAddr of 60 or more sets the pointer to 0.
- R6: The pointer steps from 59 back to 0.
- R7: An access starts with the first strobe of any kind and ends with a bus-stop strobe. The hardware subaddress is latched on every clock in which no access is open and is held while one is open.
- R8: A bus-stop strobe ends the access and leaves both the pointer and the selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| devSelStb | input | 1 | Device-select command strobe |
| devSelSub | input | 3 | Subaddress carried by the device-select command |
| loadPtrStb | input | 1 | Load-pointer command strobe |
| loadAddr | input | 6 | RAM address carried by the load-pointer command |
| dataStb | input | 1 | Display data byte strobe |
| dataByte | input | 8 | Display data byte |
| busStopStb | input | 1 | Bus stop condition strobe |
| hwSub | input | 3 | Hardware subaddress pins |
| ramWe | output | 1 | RAM write enable, one clock per stored byte |
| ramAddr | output | 6 | RAM write address |
| ramData | output | 8 | RAM write data |

## Verification
Directed sequences come first. A matching select followed by a burst of bytes shows that the write uses the address from before the increment. A mismatching select followed by bytes shows that the pointer keeps advancing while nothing is written. Loads to 58 and to 61 exercise the wrap and the out-of-range load. A pin change inside an open access, followed by a change after a stop, shows the difference between the latched subaddress and the live one. A long pseudo-random mix of strobes, stops and pin changes is then compared cycle by cycle against a behavioural model.

// File: rtl/cascade_ptr_pkg.sv
package cascade_ptr_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic writeEn;  // store the current byte at the current pointer
    logic loadPtr;  // replace the pointer with the command address
    logic advance;  // step the pointer by one
  } ctlStrobes_t;
endpackage

// File: rtl/cascade_ptr_ctrl.sv
module cascade_ptr_ctrl
  import cascade_ptr_pkg::*;
#(
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             devSelStb,
  input  logic [SUB_W-1:0] devSelSub,
  input  logic             loadPtrStb,
  input  logic             dataStb,
  input  logic             busStopStb,
  input  logic [SUB_W-1:0] hwSub,
  output ctlStrobes_t      ctl
);
  logic             accessOpen;
  logic             selected;
  logic [SUB_W-1:0] subLatch;
  logic             anyStrobe;

  assign anyStrobe = devSelStb | loadPtrStb | dataStb;

  // Access tracking: opened by any strobe, closed by a bus stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accessOpen <= 1'b0;
    else if (busStopStb) accessOpen <= 1'b0;
    else if (anyStrobe) accessOpen <= 1'b1;
  end

  // Pins are sampled only between accesses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) subLatch <= '0;
    else if (!accessOpen) subLatch <= hwSub;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selected <= 1'b0;
    else if (devSelStb) selected <= (devSelSub == subLatch);
  end

  always_comb begin
    ctl.loadPtr = loadPtrStb;
    ctl.advance = dataStb & ~loadPtrStb;
    ctl.writeEn = dataStb & selected;
  end

  a_r7_sub_held : assert property (@(posedge clk) disable iff (!rstN)
    accessOpen |=> $stable(subLatch));
  a_r8_stop_keeps_sel : assert property (@(posedge clk) disable iff (!rstN)
    (busStopStb && !devSelStb) |=> $stable(selected));
  a_r2_sel_follows_match : assert property (@(posedge clk) disable iff (!rstN)
    (devSelStb && devSelSub == subLatch) |=> selected);
endmodule

// File: rtl/cascade_ptr_dp.sv
module cascade_ptr_dp
  import cascade_ptr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 60,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] dataByte,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData
);
  localparam logic [ADDR_W-1:0] LAST    = ADDR_W'(DEPTH - 1);
  localparam logic [31:0]       DEPTH_U = 32'(DEPTH);
  localparam bit                FULL    = (DEPTH == (1 << ADDR_W));

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ptrInc;
  logic [ADDR_W-1:0] loadVal;

  generate
    if (FULL) begin : g_natural_wrap
      assign ptrInc  = ptr + 1'b1;
      assign loadVal = loadAddr;
    end else begin : g_compare_wrap
      assign ptrInc  = (ptr == LAST) ? '0 : ptr + 1'b1;
      assign loadVal = ({{(32-ADDR_W){1'b0}}, loadAddr} < DEPTH_U) ? loadAddr : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (ctl.loadPtr) ptr <= loadVal;
    else if (ctl.advance) ptr <= ptrInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramWe   <= 1'b0;
      ramAddr <= '0;
      ramData <= '0;
    end else begin
      ramWe <= ctl.writeEn;
      if (ctl.writeEn) begin
        ramAddr <= ptr;
        ramData <= dataByte;
      end
    end
  end

  a_r6_wrap : assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.loadPtr && ptr == LAST) |=> ptr == '0);
  a_r5_ptr_in_range : assert property (@(posedge clk) disable iff (!rstN)
    {{(32-ADDR_W){1'b0}}, ptr} < DEPTH_U);
  a_r3_addr_before_step : assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeEn |=> (ramWe && ramAddr == $past(ptr)));
endmodule

// File: rtl/cascade_ram_ptr.sv
module cascade_ram_ptr
  import cascade_ptr_pkg::*;
#(
  parameter int SUB_W  = 3,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 60,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              devSelStb,
  input  logic [SUB_W-1:0]  devSelSub,
  input  logic              loadPtrStb,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              dataStb,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              busStopStb,
  input  logic [SUB_W-1:0]  hwSub,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData
);
  ctlStrobes_t ctl;

  cascade_ptr_ctrl #(.SUB_W(SUB_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .devSelStb(devSelStb), .devSelSub(devSelSub),
    .loadPtrStb(loadPtrStb), .dataStb(dataStb), .busStopStb(busStopStb),
    .hwSub(hwSub), .ctl(ctl)
  );

  cascade_ptr_dp #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadAddr(loadAddr), .dataByte(dataByte),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData)
  );

  a_r4_no_write_without_strobe : assert property (@(posedge clk) disable iff (!rstN)
    !dataStb |=> !ramWe);
endmodule

// File: tb/test_cascade_ram_ptr.sv
module test_cascade_ram_ptr;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       devSelStb = 0, loadPtrStb = 0, dataStb = 0, busStopStb = 0;
  logic [2:0] devSelSub = 0, hwSub = 0;
  logic [5:0] loadAddr = 0;
  logic [7:0] dataByte = 0;
  logic       ramWe;
  logic [5:0] ramAddr;
  logic [7:0] ramData;

  int compared = 0, mismatched = 0;
  string curReq = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  cascade_ram_ptr i_cascade_ram_ptr (
    .clk(clk), .rstN(rstN), .devSelStb(devSelStb), .devSelSub(devSelSub),
    .loadPtrStb(loadPtrStb), .loadAddr(loadAddr), .dataStb(dataStb),
    .dataByte(dataByte), .busStopStb(busStopStb), .hwSub(hwSub),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData)
  );

  // Behavioural reference model
  int mPtr = 0, mSub = 0;
  bit mSel = 0, mOpen = 0, expWe = 0;
  int expAddr = 0, expData = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPtr = 0; mSub = 0; mSel = 0; mOpen = 0; expWe = 0;
    end else begin
      bit wasOpen;
      wasOpen = mOpen;
      expWe = dataStb && mSel;
      if (expWe) begin expAddr = mPtr; expData = dataByte; end
      if (devSelStb) mSel = (int'(devSelSub) == mSub);
      if (loadPtrStb) mPtr = (loadAddr < 60) ? int'(loadAddr) : 0;
      else if (dataStb) mPtr = (mPtr == 59) ? 0 : mPtr + 1;
      if (busStopStb) mOpen = 0;
      else if (devSelStb || loadPtrStb || dataStb) mOpen = 1;
      if (!wasOpen) mSub = int'(hwSub);
    end
  end

  task automatic check(string req, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, int'(ramWe), int'(expWe), "ramWe");
      if (expWe && ramWe) begin
        check(curReq, int'(ramAddr), expAddr, "ramAddr");
        check(curReq, int'(ramData), expData, "ramData");
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic sel(int s);
    devSelSub = 3'(s); devSelStb = 1; @(negedge clk); devSelStb = 0;
  endtask
  task automatic ld(int a);
    loadAddr = 6'(a); loadPtrStb = 1; @(negedge clk); loadPtrStb = 0;
  endtask
  task automatic wr(int d);
    dataByte = 8'(d); dataStb = 1; @(negedge clk); dataStb = 0;
  endtask
  task automatic stopBus();
    busStopStb = 1; @(negedge clk); busStopStb = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    hwSub = 3'd5;
    idle(3);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    check("R1", int'(ramWe), 0, "ramWe after reset");
    wr(8'h11);                        // deselected after reset: no write
    idle(1);
    check("R1", int'(ramWe), 0, "no write before select");
    stopBus(); idle(2);

    curReq = "R3";                    // select, load, burst
    sel(5); ld(10); wr(8'hA0); wr(8'hA1); wr(8'hA2);
    idle(1);
    curReq = "R2";                    // mismatch deselects
    sel(2);
    curReq = "R4";
    wr(8'hB0); wr(8'hB1); idle(1);
    check("R4", int'(ramWe), 0, "no write while deselected");
    sel(5); wr(8'hC0); idle(1);       // pointer advanced to 15

    curReq = "R6"; ld(58); wr(1); wr(2); wr(3); idle(1);
    curReq = "R5"; ld(61); wr(4); ld(33); wr(5); idle(1);

    curReq = "R8"; ld(20); stopBus(); idle(2); wr(6); idle(1);
    stopBus(); idle(2);

    curReq = "R7";
    ld(30); hwSub = 3'd3; idle(1);
    sel(3); wr(7); idle(1);           // latched 5: mismatch, no write
    sel(5); wr(8); idle(1);           // still 5 inside access
    stopBus(); idle(2);
    sel(3); wr(9); idle(1);           // new pins now latched
    stopBus(); idle(2);

    curReq = "R3";                    // pseudo-random mix
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0: sel(int'(lfsr[5:4]) + 2);
        3'd1: ld(int'(lfsr[11:6]));
        3'd2, 3'd3, 3'd4: wr(int'(lfsr[15:8]));
        3'd5: stopBus();
        3'd6: begin hwSub = 3'(lfsr[9:8] + 2); idle(1); end
        default: idle(1);
      endcase
    end
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule